// File: doc/BRIEF.md
# DDS Serial Control Word Decoder

This block sits between a host's serial port and a direct digital synthesis core. The host sends 16-bit command words over a four-wire serial link, with the clock idling high and the target listening only while its select line is low. The block brings the serial signals into the system clock domain, puts each complete word together and decodes its top bits to pick a destination. The destinations are a 14-bit control register, two 28-bit frequency tuning registers and two 12-bit phase offset registers. The register contents are driven straight out to the synthesis core.

A 28-bit tuning word does not fit in one command, so frequency writes carry only 14 bits. Two control bits set how those 14 bits land. In paired mode, two writes in a row build the whole value, low half first. The core sees nothing until the high half arrives, so it never gets a mix of old and new halves. In single-half mode, every write replaces one half only, chosen by a control bit, and the other half keeps its value. Each change the core can see is marked by a one-cycle update strobe.

Top module: `dds_word_decoder`

## Requirements
- R1: A word is accepted only when the select line goes high after exactly 16 falling edges of the serial clock. Bits are taken MSB first, one on each falling edge while select is low, and the word takes effect after select rises.
- R2: Bits [15:14] of the word pick the target: 00 control, 01 frequency 0, 10 frequency 1, 11 phase. A control write copies bits [13:0] to `ctrl_o` with the bit positions unchanged: frequency select 11, phase select 10, reset 8, sleep 7, converter off 6, MSB output 5, divide-by-two 3, triangle mode 1. A control write changes no frequency or phase register.
- R3: In a phase word, bit 13 picks phase 1 (1) or phase 0 (0), and bits [11:0] become that register's value. Bit 12 is ignored. A frequency word carries its data in bits [13:0].
- R4: With control bit 13 set (paired mode), the first frequency write holds its 14 bits as the low half and leaves every output unchanged. The next frequency write loads the addressed register with {its data, held low half} all at once.
- R5: With control bit 13 clear, a frequency write replaces only the half that control bit 12 picks (0 low [13:0], 1 high [27:14]). The other half keeps its value.
- R6: A control write resets the paired-mode pointer, so the next frequency write is taken as a low half.
- R7: A frame with fewer or more than 16 clock edges changes no register and raises no strobe.
- R8: After reset, `ctrl_o` is 0x0100 (only the reset bit set), both frequency and both phase outputs are zero, and `upd_o` is low.
- R9: `upd_o` is high for exactly one cycle for each write that changes what the core sees (control, phase, a completed pair, or a single-half write). The register outputs change only in that cycle, and a held low half raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, idles high |
| csn_i | input | 1 | Active-low frame select |
| mosi_i | input | 1 | Serial data, MSB first |
| ctrl_o | output | 14 | Control register |
| freq0_o | output | 28 | Frequency register 0 |
| freq1_o | output | 28 | Frequency register 1 |
| phase0_o | output | 12 | Phase register 0 |
| phase1_o | output | 12 | Phase register 1 |
| upd_o | output | 1 | One-cycle strobe when a visible register changes |

## Verification
The assertions assume the serial clock is slow next to the system clock. Each serial level must stay put for several system cycles so that the two-flop synchronisers never miss an edge. They also assume accepted words come far enough apart that two strobes can never be back to back. The bench keeps every serial level for four system cycles, holds select low for a few cycles before the first edge and after the last, and leaves ten idle cycles between frames. It never sends the high half of a pair to a different register from the one that got the low half.

// File: rtl/dds_pkg.sv
package dds_pkg;
    localparam int DDS_WORD_W  = 16;
    localparam int DDS_FREQ_W  = 28;
    localparam int DDS_PHASE_W = 12;
    localparam int DDS_CTRL_W  = 14;
    localparam int DDS_HALF_W  = DDS_FREQ_W / 2;

    localparam int CTRL_PAIRED_BIT = 13;
    localparam int CTRL_HALFSEL_BIT = 12;
    localparam int CTRL_RESET_BIT  = 8;

    typedef enum logic [1:0] {
        TGT_CTRL  = 2'b00,
        TGT_FREQ0 = 2'b01,
        TGT_FREQ1 = 2'b10,
        TGT_PHASE = 2'b11
    } dds_tgt_e;

    typedef struct packed {
        logic [DDS_CTRL_W-1:0]          ctrl;
        logic [1:0][DDS_FREQ_W-1:0]     freq;
        logic [1:0][DDS_PHASE_W-1:0]    phase;
        logic [DDS_HALF_W-1:0]          lo_hold;
        logic                           seq_hi;
        logic                           upd;
    } dds_bank_t;
endpackage

// File: rtl/dds_spi_rx.sv
module dds_spi_rx #(
    parameter int WORD_W = dds_pkg::DDS_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              mosi_i,
    output logic              word_vld_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_W   = $clog2(WORD_W + 2);
    localparam int CNT_MAX = WORD_W + 1;

    typedef struct packed {
        logic [2:0]        sck_sh;
        logic [2:0]        cs_sh;
        logic [1:0]        mo_sh;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sr;
        logic              vld;
        logic [WORD_W-1:0] word;
    } rx_t;

    rx_t rx_d, rx_q;
    logic sck_fall, cs_rise, cs_low;

    always_comb begin
        rx_d        = rx_q;
        rx_d.vld    = 1'b0;
        rx_d.sck_sh = {rx_q.sck_sh[1:0], sclk_i};
        rx_d.cs_sh  = {rx_q.cs_sh[1:0], csn_i};
        rx_d.mo_sh  = {rx_q.mo_sh[0], mosi_i};

        sck_fall = rx_q.sck_sh[2] & ~rx_q.sck_sh[1];
        cs_rise  = rx_q.cs_sh[1] & ~rx_q.cs_sh[2];
        cs_low   = ~rx_q.cs_sh[1];

        if (!cs_low) begin
            rx_d.cnt = '0;
            if (cs_rise && (rx_q.cnt == CNT_W'(WORD_W))) begin
                rx_d.vld  = 1'b1;
                rx_d.word = rx_q.sr;
            end
        end else if (sck_fall) begin
            rx_d.sr = {rx_q.sr[WORD_W-2:0], rx_q.mo_sh[1]};
            if (rx_q.cnt != CNT_W'(CNT_MAX)) begin
                rx_d.cnt = rx_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q        <= '0;
            rx_q.sck_sh <= '1;
            rx_q.cs_sh  <= '1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign word_vld_o = rx_q.vld;
    assign word_o     = rx_q.word;
endmodule

// File: rtl/dds_reg_bank.sv
module dds_reg_bank
    import dds_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   word_vld_i,
    input  logic [DDS_WORD_W-1:0]  word_i,
    output logic [DDS_CTRL_W-1:0]  ctrl_o,
    output logic [DDS_FREQ_W-1:0]  freq0_o,
    output logic [DDS_FREQ_W-1:0]  freq1_o,
    output logic [DDS_PHASE_W-1:0] phase0_o,
    output logic [DDS_PHASE_W-1:0] phase1_o,
    output logic                   upd_o
);
    dds_bank_t bk_d, bk_q;
    dds_tgt_e  tgt;
    logic      fidx;
    logic [DDS_HALF_W-1:0] fdata;

    always_comb begin
        bk_d     = bk_q;
        bk_d.upd = 1'b0;
        tgt      = dds_tgt_e'(word_i[DDS_WORD_W-1 -: 2]);
        fidx     = word_i[DDS_WORD_W-1];
        fdata    = word_i[DDS_HALF_W-1:0];
        if (word_vld_i) begin
            case (tgt)
                TGT_CTRL: begin
                    bk_d.ctrl   = word_i[DDS_CTRL_W-1:0];
                    bk_d.seq_hi = 1'b0;
                    bk_d.upd    = 1'b1;
                end
                TGT_FREQ0, TGT_FREQ1: begin
                    if (bk_q.ctrl[CTRL_PAIRED_BIT]) begin
                        if (!bk_q.seq_hi) begin
                            bk_d.lo_hold = fdata;
                            bk_d.seq_hi  = 1'b1;
                        end else begin
                            bk_d.freq[fidx] = {fdata, bk_q.lo_hold};
                            bk_d.seq_hi     = 1'b0;
                            bk_d.upd        = 1'b1;
                        end
                    end else begin
                        if (bk_q.ctrl[CTRL_HALFSEL_BIT]) begin
                            bk_d.freq[fidx][DDS_FREQ_W-1:DDS_HALF_W] = fdata;
                        end else begin
                            bk_d.freq[fidx][DDS_HALF_W-1:0] = fdata;
                        end
                        bk_d.upd = 1'b1;
                    end
                end
                default: begin
                    bk_d.phase[word_i[13]] = word_i[DDS_PHASE_W-1:0];
                    bk_d.upd               = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q      <= '0;
            bk_q.ctrl <= DDS_CTRL_W'(1) << CTRL_RESET_BIT;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign ctrl_o   = bk_q.ctrl;
    assign freq0_o  = bk_q.freq[0];
    assign freq1_o  = bk_q.freq[1];
    assign phase0_o = bk_q.phase[0];
    assign phase1_o = bk_q.phase[1];
    assign upd_o    = bk_q.upd;
endmodule

// File: rtl/dds_word_decoder.sv
module dds_word_decoder
    import dds_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sclk_i,
    input  logic                   csn_i,
    input  logic                   mosi_i,
    output logic [DDS_CTRL_W-1:0]  ctrl_o,
    output logic [DDS_FREQ_W-1:0]  freq0_o,
    output logic [DDS_FREQ_W-1:0]  freq1_o,
    output logic [DDS_PHASE_W-1:0] phase0_o,
    output logic [DDS_PHASE_W-1:0] phase1_o,
    output logic                   upd_o
);
    logic                  word_vld;
    logic [DDS_WORD_W-1:0] word;

    dds_spi_rx #(.WORD_W(DDS_WORD_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (sclk_i),
        .csn_i      (csn_i),
        .mosi_i     (mosi_i),
        .word_vld_o (word_vld),
        .word_o     (word)
    );

    dds_reg_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_vld_i (word_vld),
        .word_i     (word),
        .ctrl_o     (ctrl_o),
        .freq0_o    (freq0_o),
        .freq1_o    (freq1_o),
        .phase0_o   (phase0_o),
        .phase1_o   (phase1_o),
        .upd_o      (upd_o)
    );
endmodule

// File: rtl/dds_word_decoder_chk.sv
module dds_word_decoder_chk
    import dds_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   word_vld,
    input logic [DDS_WORD_W-1:0]  word,
    input logic [DDS_CTRL_W-1:0]  ctrl_o,
    input logic [DDS_FREQ_W-1:0]  freq0_o,
    input logic [DDS_FREQ_W-1:0]  freq1_o,
    input logic [DDS_PHASE_W-1:0] phase0_o,
    input logic [DDS_PHASE_W-1:0] phase1_o,
    input logic                   upd_o
);
    AST_CHANGE_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ctrl_o, freq0_o, freq1_o, phase0_o, phase1_o}) |-> upd_o); // R9

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o); // R9

    AST_STROBE_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> $past(word_vld)); // R7

    AST_CTRL_KEEPS_FREQ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(word_vld && word[15:14] == 2'b00) |-> $stable({freq0_o, freq1_o, phase0_o, phase1_o})); // R2

    AST_HALF_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(word_vld && word[15:14] == 2'b01 && !ctrl_o[CTRL_PAIRED_BIT] && !ctrl_o[CTRL_HALFSEL_BIT])
        |-> freq0_o[DDS_FREQ_W-1:DDS_HALF_W] == $past(freq0_o[DDS_FREQ_W-1:DDS_HALF_W])); // R5
endmodule

bind dds_word_decoder dds_word_decoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_vld (word_vld),
    .word     (word),
    .ctrl_o   (ctrl_o),
    .freq0_o  (freq0_o),
    .freq1_o  (freq1_o),
    .phase0_o (phase0_o),
    .phase1_o (phase1_o),
    .upd_o    (upd_o)
);

// File: tb/dds_word_decoder_tb.sv
module dds_word_decoder_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, csn = 1'b1, mosi = 1'b0;
    logic [13:0] ctrl_o;
    logic [27:0] freq0_o, freq1_o;
    logic [11:0] phase0_o, phase1_o;
    logic        upd_o;

    int total = 0;
    int bad = 0;

    logic [13:0] m_ctrl;
    logic [27:0] m_f0, m_f1;
    logic [11:0] m_p0, m_p1;
    logic        m_hi;
    logic [13:0] m_lo;

    logic [93:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    dds_word_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
        .ctrl_o(ctrl_o), .freq0_o(freq0_o), .freq1_o(freq1_o),
        .phase0_o(phase0_o), .phase1_o(phase1_o), .upd_o(upd_o)
    );

    function automatic logic [93:0] snap_model();
        return {m_ctrl, m_f0, m_f1, m_p0, m_p1};
    endfunction

    task automatic check_outs(input string tag);
        logic [93:0] act;
        act = {ctrl_o, freq0_o, freq1_o, phase0_o, phase1_o};
        total++;
        if (act !== snap_model() || upd_o !== 1'b0) begin
            bad++;
            $display("FAIL %s: outputs act=%h upd=%b exp=%h upd=0", tag, act, upd_o, snap_model());
        end
    endtask

    // Model of one accepted word, built from the requirements
    task automatic model_word(input logic [15:0] w, input string tag);
        logic vis;
        vis = 1'b1;
        case (w[15:14])
            2'b00: begin m_ctrl = w[13:0]; m_hi = 1'b0; end
            2'b11: if (w[13]) m_p1 = w[11:0]; else m_p0 = w[11:0];
            default: begin
                if (m_ctrl[13]) begin
                    if (!m_hi) begin m_lo = w[13:0]; m_hi = 1'b1; vis = 1'b0; end
                    else begin
                        m_hi = 1'b0;
                        if (w[15]) m_f1 = {w[13:0], m_lo}; else m_f0 = {w[13:0], m_lo};
                    end
                end else if (m_ctrl[12]) begin
                    if (w[15]) m_f1[27:14] = w[13:0]; else m_f0[27:14] = w[13:0];
                end else begin
                    if (w[15]) m_f1[13:0] = w[13:0]; else m_f0[13:0] = w[13:0];
                end
            end
        endcase
        if (vis) begin
            exp_q.push_back(snap_model());
            tag_q.push_back(tag);
        end
    endtask

    task automatic send_bits(input logic [15:0] w, input int nbits);
        @(negedge clk);
        csn = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? w[15-i] : 1'b0;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
            sclk = 1'b1;
        end
        repeat (4) @(negedge clk);
        csn = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    // Driver: push expected result, then drive the frame
    task automatic write_word(input logic [15:0] w, input string tag);
        model_word(w, tag);
        send_bits(w, 16);
    endtask

    // Monitor: compare on every strobe
    always @(negedge clk) begin
        if (rst_n && upd_o) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R9: unexpected strobe act=%h exp=none",
                         {ctrl_o, freq0_o, freq1_o, phase0_o, phase1_o});
            end else begin
                logic [93:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({ctrl_o, freq0_o, freq1_o, phase0_o, phase1_o} !== e) begin
                    bad++;
                    $display("FAIL %s: act=%h exp=%h", t,
                             {ctrl_o, freq0_o, freq1_o, phase0_o, phase1_o}, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_ctrl = 14'h0100; m_f0 = '0; m_f1 = '0; m_p0 = '0; m_p1 = '0;
        m_hi = 1'b0; m_lo = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_outs("R8 reset state");

        // paired mode
        write_word(16'h2000, "R2 ctrl write");
        write_word(16'h4000 | 16'h1234, "R4 low half");
        check_outs("R4 low half held, no change");
        write_word(16'h4000 | 16'h0ABC, "R4 pair to freq0");
        write_word(16'h8000 | 16'h3FFF, "R4 low half f1");
        write_word(16'h8000 | 16'h0001, "R4 pair to freq1");

        // phase
        write_word(16'hC000 | 16'h0ABC, "R3 phase0");
        write_word(16'hF123, "R3 phase1 bit12 ignored");

        // pointer reset
        write_word(16'h4000 | 16'h0111, "R6 stray low half");
        write_word(16'h2000, "R6 ctrl resets pointer");
        write_word(16'h4000 | 16'h0222, "R6 new low half");
        check_outs("R6 after new low half");
        write_word(16'h4000 | 16'h0333, "R6 pair after reset");

        // single-half mode
        write_word(16'h1000, "R5 ctrl halfsel high");
        write_word(16'h8000 | 16'h2AAA, "R5 high half of freq1");
        write_word(16'h0000, "R5 ctrl halfsel low");
        write_word(16'h8000 | 16'h1555, "R5 low half of freq1");
        write_word(16'h4000 | 16'h0777, "R5 low half of freq0");

        // control field positions
        write_word(16'h0DAA, "R2 ctrl bit positions");

        // bad frame lengths
        send_bits(16'hC555, 15);
        check_outs("R7 short frame ignored");
        send_bits(16'hC555, 17);
        check_outs("R7 long frame ignored");
        write_word(16'hE0F0, "R1 good frame after bad");

        repeat (10) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R9: pending act=%0d exp=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule